// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Unit

This block watches the already-synchronized input values of one GPIO bank and turns pin activity into latched interrupt status. Every pin carries three sense bits: one chooses level or edge detection, one enables detection on both edges, and one gives the polarity. In edge mode the polarity picks rising or falling. In level mode it picks the active-high or the active-low level. A detected event sets a sticky raw status bit. That bit is set even when the pin is masked.

Software clears status by pulsing a one in a pin's position of the write-one-to-clear vector. The masked status (raw status gated by the per-pin enable) is presented as its own vector. A single interrupt line carries a registered OR of the masked bits. It is meant to sit behind a bank's register decode, and the register decode is not part of this block.

Top module: `gpio_irq_sense`

## Requirements
- R1: With `cfg_level[n]`=1 and `cfg_pol[n]`=1, raw status bit n is set at every clock edge where `pin_in[n]` is 1.
- R2: With `cfg_level[n]`=1 and `cfg_pol[n]`=0, raw status bit n is set at every clock edge where `pin_in[n]` is 0.
- R3: In edge mode (`cfg_level[n]`=0, `cfg_both[n]`=0), `cfg_pol[n]`=1 sets raw status bit n at the edge where `pin_in[n]` is sampled 1 after having been sampled 0. Falling transitions do not set it.
- R4: In edge mode with `cfg_both[n]`=0 and `cfg_pol[n]`=0, only a 1-to-0 transition of `pin_in[n]` sets raw status bit n.
- R5: In edge mode with `cfg_both[n]`=1, either transition direction sets raw status bit n, whatever the value of `cfg_pol[n]`.
- R6: `masked_status` equals `raw_status` AND `irq_en` bit by bit, where `irq_en[n]`=1 enables pin n.
- R7: Raw status is sticky. A 1 in `clr_w1c[n]` clears bit n at the next edge. A 0 in `clr_w1c[n]` leaves bit n unchanged.
- R8: An edge event and a clear on the same pin in the same cycle leave that pin's raw status set.
- R9: In level mode, a clear drops the status for one cycle. The status is set again at the following edge if the active level is still present.
- R10: `irq_out` is a register that holds the OR of `masked_status` as it stood before the last clock edge. This gives one cycle of latency.
- R11: Raw status latches while a pin is masked. Setting `irq_en[n]` makes `masked_status[n]` rise in the same cycle.
- R12: Reset clears all status and `irq_out`. The first sample taken after reset is never treated as an edge. Pin n always maps to bit n of every per-pin vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Synchronized pin values |
| cfg_level | input | 32 | 1 = level sense, 0 = edge sense |
| cfg_both | input | 32 | 1 = trigger on both edges (edge mode only) |
| cfg_pol | input | 32 | Edge: 1 rising / 0 falling; level: 1 high / 0 low |
| irq_en | input | 32 | Per-pin interrupt enable (mask) |
| clr_w1c | input | 32 | Write-one-to-clear pulse vector |
| raw_status | output | 32 | Sticky latched event status |
| masked_status | output | 32 | Raw status gated by `irq_en` |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
A clear and a new detection can land on the same pin in the same cycle, and the result depends on the sense mode. In edge mode the event wins. In level mode the clear wins for exactly one cycle. Directed cases drive a fresh transition together with a clear on the same bits, and they pulse a clear against a level that is held active. The status is then compared at the following edge and at the edge after that. Random phases pulse sparse clears against sparse pin toggles under shifting configurations. Every cycle is compared with a bench model that updates status in the order the requirements give.

// File: rtl/gis_pkg.sv
package gis_pkg;

  // Edge qualifier: dual-edge overrides polarity.
  function automatic logic edge_match(input logic both, input logic pol,
                                      input logic rise, input logic fall);
    return both ? (rise | fall) : (pol ? rise : fall);
  endfunction

  // Level qualifier: polarity selects the active level.
  function automatic logic level_match(input logic pol, input logic pin);
    return pol ? pin : ~pin;
  endfunction

  // Next status: an edge event beats a clear, a level hit does not.
  function automatic logic next_status(input logic cur, input logic clr,
                                       input logic e_hit, input logic l_hit);
    return e_hit | ((l_hit | cur) & ~clr);
  endfunction

endpackage

// File: rtl/gis_edge_detect.sv
module gis_edge_detect #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] rise,
  output logic [PINS-1:0] fall
);

  logic [PINS-1:0] prev_q;
  logic            primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_in;
      primed_q <= 1'b1;
    end
  end

  // No transition is reported until one real sample has been taken.
  assign rise = {PINS{primed_q}} &  pin_in & ~prev_q;
  assign fall = {PINS{primed_q}} & ~pin_in &  prev_q;

endmodule

// File: rtl/gis_sense_sel.sv
module gis_sense_sel
  import gis_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] rise,
  input  logic [PINS-1:0] fall,
  input  logic [PINS-1:0] cfg_level,
  input  logic [PINS-1:0] cfg_both,
  input  logic [PINS-1:0] cfg_pol,
  output logic [PINS-1:0] edge_evt,
  output logic [PINS-1:0] level_evt
);

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    assign edge_evt[g]  = ~cfg_level[g] &
                          edge_match(cfg_both[g], cfg_pol[g], rise[g], fall[g]);
    assign level_evt[g] =  cfg_level[g] & level_match(cfg_pol[g], pin_in[g]);
  end

endmodule

// File: rtl/gis_status_bank.sv
module gis_status_bank
  import gis_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] edge_evt,
  input  logic [PINS-1:0] level_evt,
  input  logic [PINS-1:0] clr_w1c,
  input  logic [PINS-1:0] irq_en,
  output logic [PINS-1:0] raw_status,
  output logic [PINS-1:0] masked_status,
  output logic            irq_out
);

  logic [PINS-1:0] stat_q;
  logic            irq_q;

  for (genvar g = 0; g < PINS; g++) begin : g_stat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[g] <= 1'b0;
      else        stat_q[g] <= next_status(stat_q[g], clr_w1c[g],
                                           edge_evt[g], level_evt[g]);
    end
  end

  assign raw_status    = stat_q;
  assign masked_status = stat_q & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |masked_status;
  end

  assign irq_out = irq_q;

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] cfg_level,
  input  logic [PINS-1:0] cfg_both,
  input  logic [PINS-1:0] cfg_pol,
  input  logic [PINS-1:0] irq_en,
  input  logic [PINS-1:0] clr_w1c,
  output logic [PINS-1:0] raw_status,
  output logic [PINS-1:0] masked_status,
  output logic            irq_out
);

  logic [PINS-1:0] rise;
  logic [PINS-1:0] fall;
  logic [PINS-1:0] edge_evt;
  logic [PINS-1:0] level_evt;

  gis_edge_detect #(.PINS(PINS)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .rise   (rise),
    .fall   (fall)
  );

  gis_sense_sel #(.PINS(PINS)) u_sel (
    .pin_in    (pin_in),
    .rise      (rise),
    .fall      (fall),
    .cfg_level (cfg_level),
    .cfg_both  (cfg_both),
    .cfg_pol   (cfg_pol),
    .edge_evt  (edge_evt),
    .level_evt (level_evt)
  );

  gis_status_bank #(.PINS(PINS)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .edge_evt      (edge_evt),
    .level_evt     (level_evt),
    .clr_w1c       (clr_w1c),
    .irq_en        (irq_en),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq_out       (irq_out)
  );

endmodule

// File: rtl/gis_checker.sv
module gis_checker #(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] clr_w1c,
  input logic [PINS-1:0] irq_en,
  input logic [PINS-1:0] cfg_level,
  input logic [PINS-1:0] edge_evt,
  input logic [PINS-1:0] raw_status,
  input logic [PINS-1:0] masked_status,
  input logic            irq_out
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_mask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked_status & ~irq_en) | (masked_status & ~raw_status)) == '0);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(raw_status) & ~$past(clr_w1c) & ~raw_status) == '0));

  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(edge_evt) & ~raw_status) == '0));

  assert_level_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(clr_w1c) & $past(cfg_level) & raw_status) == '0));

  assert_irq_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_out == (|$past(masked_status))));

endmodule

bind gpio_irq_sense gis_checker #(.PINS(PINS)) u_gis_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr_w1c       (clr_w1c),
  .irq_en        (irq_en),
  .cfg_level     (cfg_level),
  .edge_evt      (edge_evt),
  .raw_status    (raw_status),
  .masked_status (masked_status),
  .irq_out       (irq_out)
);

// File: tb/gpio_irq_sense_test.sv
module gpio_irq_sense_test;

  localparam int PINS       = 32;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PINS-1:0] pin = '0, lvl = '0, both = '0, pol = '0, en = '0, clr = '0;
  logic [PINS-1:0] raw, msk;
  logic            irq;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R12";

  logic [PINS-1:0] stat_m = '0;
  logic [PINS-1:0] prev_m = '0;
  logic            primed_m = 1'b0;
  logic            irq_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_sense #(.PINS(PINS)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin), .cfg_level(lvl), .cfg_both(both),
    .cfg_pol(pol), .irq_en(en), .clr_w1c(clr),
    .raw_status(raw), .masked_status(msk), .irq_out(irq)
  );

  // Bench's own view of one pin per requirement.
  function automatic logic pin_next(logic cur, logic c, logic l, logic b, logic p,
                                    logic now, logic was, logic ok);
    logic up, down, hit_e, hit_l;
    up    = ok & now & ~was;
    down  = ok & ~now & was;
    hit_e = !l && (b ? (up || down) : (p ? up : down));
    hit_l = l && (now == p);
    if (hit_e) return 1'b1;        // R8: edge beats clear
    if (c)     return 1'b0;        // R7 / R9
    return cur | hit_l;
  endfunction

  task automatic check(string what, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("raw_status", raw, stat_m);
    check("masked_status", msk, stat_m & en);
    check("irq_out", {{(PINS-1){1'b0}}, irq}, {{(PINS-1){1'b0}}, irq_m});
  endtask

  task automatic step();
    @(posedge clk);
    irq_m = |(stat_m & en);
    for (int i = 0; i < PINS; i++)
      stat_m[i] = pin_next(stat_m[i], clr[i], lvl[i], both[i], pol[i],
                           pin[i], prev_m[i], primed_m);
    prev_m   = pin;
    primed_m = 1'b1;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R12: pins high and rising sense during reset
    pin = '1; pol = '1;
    repeat (3) @(negedge clk);
    cur_req = "R12";
    compare_all();
    rst_n = 1'b1;
    step();                                   // first sample: no edge
    // R3: rising only
    cur_req = "R3";
    pin = '0; step();
    pin = 32'h8000_00F1; step();              // R12 bit mapping, bit 31 and 0
    pin = '0; step();                         // falling ignored
    cur_req = "R7";
    clr = '1; step(); clr = '0;
    // R4: falling only
    cur_req = "R4";
    pol = '0; pin = 32'h0000_F100; step();
    pin = '0; step();
    cur_req = "R7";
    step();                                   // clr=0 has no effect
    clr = 32'h0000_0100; step(); clr = '0;
    // R5: both edges, polarity irrelevant
    cur_req = "R5";
    both = '1; pol = 32'h0F0F_0F0F;
    clr = '1; step(); clr = '0;
    pin = 32'hAAAA_0000; step();
    clr = '1; step(); clr = '0;
    pin = '0; step();
    // R8: edge and clear together
    cur_req = "R8";
    both = '0; pol = '1;
    clr = '1; step(); clr = '0;
    pin = 32'h0000_0003; clr = 32'h0000_0003; step(); clr = '0;
    step();
    // R1 / R2 / R9 level sensing
    cur_req = "R9";
    lvl = '1; pol = 32'hFFFF_0000; pin = 32'h00FF_00FF;
    clr = '1; step(); clr = '0;
    cur_req = "R1";
    step();
    cur_req = "R2";
    step();
    cur_req = "R9";
    clr = 32'h00FF_FF00; step(); clr = '0;
    step();
    // R11 / R10 masking and summary latency
    cur_req = "R11";
    lvl = '0; pol = '1; both = '0;
    clr = '1; step(); clr = '0;
    pin = 32'h8000_0000; step();
    step();
    en = 32'h8000_0000; #1;
    check("masked_status same cycle", msk, stat_m & en);
    cur_req = "R10";
    step();
    en = '0; step();
    step();
    // R6 random phase
    cur_req = "R6";
    for (int k = 0; k < 800; k++) begin
      if (k % 40 == 0) begin
        lvl  = $urandom & $urandom;
        both = $urandom;
        pol  = $urandom;
        en   = $urandom;
      end
      pin = pin ^ ($urandom & $urandom & $urandom);
      clr = $urandom & $urandom & $urandom;
      step();
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule